// File: doc/BRIEF.md
# Bit-Test Conditional Branch Unit

This unit carries out one instruction class: test one bit of a byte in the lowest 256 locations of memory and branch on its value. The caller hands it the three instruction bytes together with the address of the opcode byte, and pulses `start`.

The opcode byte selects the bit and the branch polarity. The second byte is a zero-page address, and the unit reads that byte through a byte-wide read port whose latency is a parameter. The third byte is a signed displacement.

When the selected bit meets the polarity condition, the unit adds the sign-extended displacement to the address that follows the instruction and returns that as the next program counter. Otherwise it returns the sequential address. In both cases the tested bit value is reported as a carry result.

The unit handles one instruction at a time. It raises `busy` from acceptance until its result is ready. It then pulses `done` for one cycle, and the results stay on the outputs until the next completion.

Top module: `bitbr_unit`

## Requirements
- R1: While idle, `start` with an opcode whose upper four bits are 0000 is accepted on that clock edge, and `busy` is high in the following cycle.
- R2: Each accepted instruction makes exactly one read strobe (`mem_rd_en` high for one cycle), with `mem_addr` equal to the second instruction byte zero-extended (upper address bits all 0).
- R3: Opcode bits [3:1] give the number of the tested bit (0 = least significant) of the byte read.
- R4: Opcode bit [0] gives the polarity: 0 branches when the tested bit is 1, and 1 branches when it is 0. `taken` reports the decision.
- R5: On a taken branch, `next_pc` = `pc` + 3 + sign-extended third byte, modulo 2^PC_W, which reaches -128..+127 around the following address.
- R6: On a branch not taken, `next_pc` = `pc` + 3 modulo 2^PC_W.
- R7: `carry` takes the tested bit value at every completion, taken or not, and holds its value between completions.
- R8: `done` is a one-cycle pulse that rises READ_LAT+1 clock edges after the accepting edge. The read data is sampled READ_LAT cycles after the cycle of the strobe.
- R9: A `start` seen while busy, or with opcode upper bits not 0000, is ignored: it causes no read strobe and no `done`, and leaves `carry` unchanged.
- R10: Synchronous active-high reset clears `busy`, `done`, `taken`, `carry`, `next_pc` and `mem_rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to execute the presented instruction |
| opcode | input | 8 | First instruction byte: 0000_bbbc |
| dir_byte | input | 8 | Second byte: zero-page address of the tested byte |
| off_byte | input | 8 | Third byte: signed displacement |
| pc | input | PC_W | Address of the opcode byte |
| mem_rd_en | output | 1 | Read strobe |
| mem_addr | output | PC_W | Read address |
| mem_rd_data | input | 8 | Read data, valid READ_LAT cycles after the strobe cycle |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| taken | output | 1 | Branch decision of the last instruction |
| carry | output | 1 | Tested bit value of the last instruction |
| next_pc | output | PC_W | Next program counter of the last instruction |

## Verification
The bench builds the unit with PC_W = 16 and READ_LAT = 3. The longer latency drives the wait counter through several states, and it separates the strobe cycle from the capture cycle, so an off-by-one in the data sampling point shows up as a wrong carry. With a 16-bit counter, the corner cases near 0xFFFF and 0x0000 reach wrap-around in both directions, for the taken and the sequential paths. The extreme displacements 0x7F and 0x80 are also in reach.

// File: rtl/bitbr_pkg.sv
`timescale 1ns/1ps
package bitbr_pkg;

    localparam int BYTE_W  = 8;
    localparam int INSN_LEN = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } bitbr_state_t;

    typedef struct packed {
        logic       legal;
        logic [2:0] bit_sel;
        logic       on_clear;
    } bitbr_dec_t;

    typedef struct packed {
        logic bit_val;
        logic take;
    } bitbr_cond_t;

    function automatic bitbr_dec_t decode_op(input logic [BYTE_W-1:0] op);
        bitbr_dec_t d;
        d.legal    = (op[7:4] == 4'b0000);
        d.bit_sel  = op[3:1];
        d.on_clear = op[0];
        return d;
    endfunction

    function automatic bitbr_cond_t eval_cond(input logic [BYTE_W-1:0] data,
                                              input bitbr_dec_t      d);
        bitbr_cond_t c;
        c.bit_val = data[d.bit_sel];
        c.take    = d.on_clear ? ~c.bit_val : c.bit_val;
        return c;
    endfunction

    function automatic logic [31:0] sext_byte(input logic [BYTE_W-1:0] b);
        return {{(32-BYTE_W){b[BYTE_W-1]}}, b};
    endfunction

endpackage

// File: rtl/bitbr_decode.sv
`timescale 1ns/1ps
module bitbr_decode
    import bitbr_pkg::*;
(
    input  logic [BYTE_W-1:0] opcode,
    output bitbr_dec_t        dec
);
    always_comb begin
        dec = decode_op(opcode);
    end
endmodule

// File: rtl/bitbr_ctrl.sv
`timescale 1ns/1ps
module bitbr_ctrl
    import bitbr_pkg::*;
#(
    parameter int READ_LAT = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic legal,
    output logic accept,
    output logic issue,
    output logic capture,
    output logic busy
);
    localparam int CW = (READ_LAT > 1) ? $clog2(READ_LAT) : 1;
    localparam logic [CW-1:0] LAST = CW'(READ_LAT - 1);

    bitbr_state_t state_q;
    logic [CW-1:0] cnt_q;

    assign accept  = (state_q == ST_IDLE) && start && legal;
    assign issue   = (state_q == ST_ISSUE);
    assign capture = (state_q == ST_WAIT) && (cnt_q == LAST);
    assign busy    = (state_q != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) state_q <= ST_ISSUE;
                end
                ST_ISSUE: begin
                    state_q <= ST_WAIT;
                    cnt_q   <= '0;
                end
                ST_WAIT: begin
                    if (cnt_q == LAST) state_q <= ST_IDLE;
                    else               cnt_q   <= cnt_q + 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bitbr_resolve.sv
`timescale 1ns/1ps
module bitbr_resolve
    import bitbr_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic [BYTE_W-1:0] rd_data,
    input  bitbr_dec_t        dec,
    input  logic [PC_W-1:0]   pc_base,
    input  logic [BYTE_W-1:0] disp,
    output logic              bit_val,
    output logic              take,
    output logic [PC_W-1:0]   pc_out
);
    logic [31:0]     disp_ext;
    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] tgt_pc;
    bitbr_cond_t     cond;

    always_comb begin
        cond     = eval_cond(rd_data, dec);
        disp_ext = sext_byte(disp);
        seq_pc   = pc_base + PC_W'(INSN_LEN);
        tgt_pc   = seq_pc + disp_ext[PC_W-1:0];
        bit_val  = cond.bit_val;
        take     = cond.take;
        pc_out   = cond.take ? tgt_pc : seq_pc;
    end
endmodule

// File: rtl/bitbr_unit.sv
`timescale 1ns/1ps
module bitbr_unit
    import bitbr_pkg::*;
#(
    parameter int PC_W     = 16,
    parameter int READ_LAT = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [7:0]      opcode,
    input  logic [7:0]      dir_byte,
    input  logic [7:0]      off_byte,
    input  logic [PC_W-1:0] pc,
    output logic            mem_rd_en,
    output logic [PC_W-1:0] mem_addr,
    input  logic [7:0]      mem_rd_data,
    output logic            busy,
    output logic            done,
    output logic            taken,
    output logic            carry,
    output logic [PC_W-1:0] next_pc
);
    localparam int HI_W = PC_W - BYTE_W;

    bitbr_dec_t        dec_in, dec_q;
    logic [BYTE_W-1:0] dir_q, off_q;
    logic [PC_W-1:0]   pc_q;
    logic              accept, issue, capture;
    logic              r_bit, r_take;
    logic [PC_W-1:0]   r_pc;

    bitbr_decode u_dec (
        .opcode (opcode),
        .dec    (dec_in)
    );

    bitbr_ctrl #(.READ_LAT(READ_LAT)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .legal   (dec_in.legal),
        .accept  (accept),
        .issue   (issue),
        .capture (capture),
        .busy    (busy)
    );

    bitbr_resolve #(.PC_W(PC_W)) u_res (
        .rd_data (mem_rd_data),
        .dec     (dec_q),
        .pc_base (pc_q),
        .disp    (off_q),
        .bit_val (r_bit),
        .take    (r_take),
        .pc_out  (r_pc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q <= '0;
            dir_q <= '0;
            off_q <= '0;
            pc_q  <= '0;
        end else if (accept) begin
            dec_q <= dec_in;
            dir_q <= dir_byte;
            off_q <= off_byte;
            pc_q  <= pc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done    <= 1'b0;
            taken   <= 1'b0;
            carry   <= 1'b0;
            next_pc <= '0;
        end else begin
            done <= capture;
            if (capture) begin
                taken   <= r_take;
                carry   <= r_bit;
                next_pc <= r_pc;
            end
        end
    end

    assign mem_rd_en = issue;
    assign mem_addr  = {{HI_W{1'b0}}, dir_q};
endmodule

// File: rtl/bitbr_unit_chk.sv
`timescale 1ns/1ps
module bitbr_unit_chk #(
    parameter int PC_W = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic [7:0]      opcode,
    input logic [PC_W-1:0] pc,
    input logic            mem_rd_en,
    input logic [PC_W-1:0] mem_addr,
    input logic            busy,
    input logic            done,
    input logic            taken,
    input logic            carry,
    input logic [PC_W-1:0] next_pc
);
    logic [PC_W-1:0] pc_seen;
    logic            take_in;

    assign take_in = !busy && start && (opcode[7:4] == 4'b0000);

    always_ff @(posedge clk) begin
        if (rst)          pc_seen <= '0;
        else if (take_in) pc_seen <= pc;
    end

    // R1
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        take_in |=> busy);

    // R2
    zero_page_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> (mem_addr[PC_W-1:8] == '0) && busy);

    // R2
    single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !mem_rd_en);

    // R6
    seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !taken) |-> (next_pc == pc_seen + PC_W'(3)));

    // R7
    carry_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(carry));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    reject_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && (opcode[7:4] != 4'b0000)) |=> !busy);

    // R10
    reset_chk: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !done && !mem_rd_en && !carry && !taken));
endmodule

bind bitbr_unit bitbr_unit_chk #(.PC_W(PC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .opcode    (opcode),
    .pc        (pc),
    .mem_rd_en (mem_rd_en),
    .mem_addr  (mem_addr),
    .busy      (busy),
    .done      (done),
    .taken     (taken),
    .carry     (carry),
    .next_pc   (next_pc)
);

// File: tb/tb_bitbr_unit.sv
`timescale 1ns/1ps
module tb_bitbr_unit;
    localparam int PC_W = 16;
    localparam int LAT  = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic [7:0]      opcode = '0, dir_byte = '0, off_byte = '0;
    logic [PC_W-1:0] pc = '0;
    logic            mem_rd_en, busy, done, taken, carry;
    logic [PC_W-1:0] mem_addr, next_pc;
    logic [7:0]      mem_rd_data;

    logic [7:0]      mem [256];
    logic [PC_W-1:0] pipe [LAT];

    int n_chk = 0, n_fail = 0;
    int rd_cnt = 0, done_cnt = 0;
    logic [PC_W-1:0] last_addr = '0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    bitbr_unit #(.PC_W(PC_W), .READ_LAT(LAT)) dut (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode),
        .dir_byte(dir_byte), .off_byte(off_byte), .pc(pc),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_data(mem_rd_data),
        .busy(busy), .done(done), .taken(taken), .carry(carry), .next_pc(next_pc)
    );

    // memory model: data for an address strobed in cycle k is valid LAT cycles later
    always @(posedge clk) begin
        pipe[0] <= mem_addr;
        for (int i = 1; i < LAT; i++) pipe[i] <= pipe[i-1];
    end
    assign mem_rd_data = mem[pipe[LAT-1][7:0]];

    always @(negedge clk) begin
        if (mem_rd_en) begin
            rd_cnt++;
            last_addr = mem_addr;
        end
        if (done) done_cnt++;
    end

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [PC_W-1:0] exp_pc(input logic [PC_W-1:0] p,
                                               input logic [7:0] off, input bit tk);
        logic [PC_W-1:0] s;
        s = p + PC_W'(3);
        return tk ? s + {{(PC_W-8){off[7]}}, off} : s;
    endfunction

    task automatic run_op(input logic [7:0] op, input logic [7:0] dir,
                          input logic [7:0] off, input logic [PC_W-1:0] p,
                          input bit poke);
        int rd0, edges;
        bit eb, et;
        logic [PC_W-1:0] ep;
        @(negedge clk);
        start = 1; opcode = op; dir_byte = dir; off_byte = off; pc = p;
        rd0 = rd_cnt;
        @(posedge clk); #1;
        check(busy == 1'b1, "R1 busy after accept", busy, 1);
        if (poke) begin
            opcode = 8'h0E; dir_byte = dir ^ 8'h5A; off_byte = ~off; pc = ~p;
            @(posedge clk); #1;
        end
        start = 0;
        edges = poke ? 1 : 0;
        while (!done && edges < 40) begin
            @(posedge clk); #1;
            edges++;
        end
        eb = mem[dir][op[3:1]];
        et = op[0] ? !eb : eb;
        ep = exp_pc(p, off, et);
        check(edges == LAT + 1, "R8 done latency", edges, LAT + 1);
        check(carry == eb, "R3/R7 carry is tested bit", carry, eb);
        check(taken == et, "R4 branch polarity", taken, et);
        if (et) check(next_pc == ep, "R5 taken target", next_pc, ep);
        else    check(next_pc == ep, "R6 sequential pc", next_pc, ep);
        check(rd_cnt - rd0 == 1, poke ? "R9 busy start gives no extra read" : "R2 one strobe",
              rd_cnt - rd0, 1);
        check(last_addr == {8'h00, dir}, "R2 zero-page address", last_addr, {8'h00, dir});
        @(posedge clk); #1;
        check(done == 1'b0, "R8 done one cycle", done, 0);
        check(carry == eb, "R7 carry held", carry, eb);
    endtask

    task automatic run_bad(input logic [7:0] op);
        int rd0, dn0;
        logic c0;
        @(negedge clk);
        rd0 = rd_cnt; dn0 = done_cnt; c0 = carry;
        start = 1; opcode = op; dir_byte = 8'h33; off_byte = 8'h10; pc = 16'h1234;
        @(negedge clk);
        start = 0;
        repeat (LAT + 6) @(negedge clk);
        check(rd_cnt == rd0, "R9 illegal opcode no read", rd_cnt, rd0);
        check(done_cnt == dn0, "R9 illegal opcode no done", done_cnt, dn0);
        check(carry == c0, "R9 illegal opcode carry unchanged", carry, c0);
        check(busy == 1'b0, "R9 illegal opcode stays idle", busy, 0);
    endtask

    initial begin
        logic [31:0] r;
        r = $urandom(32'd24680);
        for (int a = 0; a < 256; a++) mem[a] = 8'($urandom());
        mem[8'h40] = 8'hA5;
        mem[8'h41] = 8'h00;
        mem[8'hFF] = 8'hFF;

        repeat (3) @(negedge clk);
        check(!busy && !done && !mem_rd_en && !carry && !taken && next_pc == 0,
              "R10 reset state", {busy, done, mem_rd_en, carry, taken}, 0);
        rst = 0;

        // directed: bit numbers and polarities on 0xA5
        for (int b = 0; b < 8; b++) begin
            run_op({4'h0, 3'(b), 1'b0}, 8'h40, 8'h10, 16'h0200, 0); // R3 R4 set
            run_op({4'h0, 3'(b), 1'b1}, 8'h40, 8'hF0, 16'h0200, 0); // R3 R4 clear
        end
        // R5 extreme displacements and wrap
        run_op(8'h00, 8'hFF, 8'h7F, 16'hFFF0, 0);
        run_op(8'h0E, 8'hFF, 8'h80, 16'h0005, 0);
        run_op(8'h0F, 8'h41, 8'h80, 16'h0002, 0);
        // R6 sequential wrap
        run_op(8'h01, 8'hFF, 8'h22, 16'hFFFE, 0);
        run_op(8'h06, 8'h41, 8'h7F, 16'hFFFD, 0);
        // R9 start while busy
        run_op(8'h04, 8'h40, 8'h05, 16'h0100, 1);
        // R9 illegal opcodes
        run_bad(8'h10);
        run_bad(8'hFF);
        run_bad(8'h80);

        // constrained random
        for (int k = 0; k < 300; k++) begin
            r = $urandom();
            run_op({4'h0, r[3:0]}, r[11:4], r[19:12], PC_W'($urandom()), r[20] & r[21]);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule